// File: doc/BRIEF.md
# Integer Add/AND Execute Unit with Overflow Trap

This unit executes one 32-bit instruction word from a small set of integer operations. The supported forms are signed and unsigned add, and bitwise AND, each in two variants: register with register, and register with a 16-bit immediate. The caller supplies the values of the two source registers beside the instruction word. The unit returns a 32-bit result, the index of the destination register and a register write enable. It also returns an overflow trap flag for the signed add forms and an illegal-instruction flag for every other encoding.

Signed and unsigned add produce the same wrapped sum. Only the signed forms check for two's-complement overflow. When they overflow, the unit raises the trap and withholds the register write. A write aimed at register 0 is also withheld, because that register always reads as zero.

All outputs are registered. An instruction presented with `in_valid` high appears on the outputs one clock later, with `out_valid` high.

Top module: `alu_trap_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `wr_en`, `ovf_trap` and `illegal` are all 0.
- R2: An instruction accepted with `in_valid` high at a rising edge appears on the outputs after that edge, with `out_valid` high. A cycle with `in_valid` low gives `out_valid`, `wr_en`, `ovf_trap` and `illegal` all 0 after the next edge.
- R3: Register form: opcode bits 31:26 equal 0, bits 10:6 equal 0, and function bits 5:0 select the operation. 0x20 selects signed add and 0x21 selects unsigned add; both give `opnd_a + opnd_b` mod 2^32. 0x24 selects `opnd_a & opnd_b`. The destination is bits 15:11.
- R4: Opcodes 0x08 (signed) and 0x09 (unsigned) add `opnd_a` to bits 15:0 sign-extended to 32 bits. The destination is bits 20:16, and `opnd_b` has no effect on the result.
- R5: Opcode 0x0C gives `opnd_a` AND bits 15:0 zero-extended to 32 bits. The destination is bits 20:16.
- R6: For the signed forms (function 0x20, opcode 0x08), overflow is defined as both addends sharing a sign while the sum has the other sign. On overflow, `ovf_trap` is 1 and `wr_en` is 0, while `result` still shows the wrapped sum.
- R7: The unsigned forms (function 0x21, opcode 0x09) never raise `ovf_trap`, and they write even when the signed view of the sum wraps.
- R8: A legal instruction whose destination is register 0 gives `wr_en` 0. Its `result` and `ovf_trap` are reported as usual.
- R9: Any other encoding is illegal. This covers every other opcode, every other function value, and a nonzero value in bits 10:6 of the register form. An illegal instruction gives `illegal` 1, `wr_en` 0, `ovf_trap` 0, `result` 0 and `dest_idx` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word |
| opnd_a | input | 32 | Value of the first source register (bits 25:21) |
| opnd_b | input | 32 | Value of the second source register (bits 20:16) |
| out_valid | output | 1 | Registered outputs belong to an accepted instruction |
| result | output | 32 | Computed value |
| dest_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Register write permitted |
| ovf_trap | output | 1 | Signed add overflowed |
| illegal | output | 1 | Encoding not recognised |

## Verification
Sums are tried at both signed limits, positive plus positive and negative plus negative, and with mixed signs. These patterns separate a correct overflow rule from one that looks only at the carry out or only at the sum's sign. The same wrapping operands go through the unsigned forms, which shows that the trap is tied to the opcode and not to the arithmetic. An all-ones immediate through the AND form and through the add forms tells zero extension from sign extension. Encodings that differ from legal ones only in the shift field, in the function code or in the opcode check that decoding is exact, and writes aimed at register 0 show that write suppression is kept apart from the trap.

// File: rtl/alu_trap_pkg.sv
package alu_trap_pkg;

  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;
  localparam int IMM_W  = 16;
  localparam int OPC_W  = 6;
  localparam int FN_W   = 6;
  localparam int SH_W   = 5;

  localparam int OPC_LSB = XLEN - OPC_W;
  localparam int RS_LSB  = OPC_LSB - RIDX_W;
  localparam int RT_LSB  = RS_LSB - RIDX_W;
  localparam int RD_LSB  = RT_LSB - RIDX_W;
  localparam int SH_LSB  = RD_LSB - SH_W;

  localparam logic [OPC_W-1:0] OPC_REGOP = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;

  localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FN_W-1:0] FN_AND  = 6'h24;

  typedef enum logic [1:0] {
    ALU_NOP = 2'd0,
    ALU_ADD = 2'd1,
    ALU_AND = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic              legal;
    alu_op_e           op;
    logic              use_imm;
    logic              trap_en;
    logic [RIDX_W-1:0] dest;
    logic [XLEN-1:0]   imm_val;
  } dec_t;

  function automatic logic [XLEN-1:0] imm_sext(input logic [IMM_W-1:0] v);
    return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] imm_zext(input logic [IMM_W-1:0] v);
    return {{(XLEN-IMM_W){1'b0}}, v};
  endfunction

  function automatic logic [XLEN-1:0] wrap_add(input logic [XLEN-1:0] x,
                                               input logic [XLEN-1:0] y);
    return x + y;
  endfunction

  // Same-sign addends with a sum of the other sign.
  function automatic logic twos_ovf(input logic [XLEN-1:0] x,
                                    input logic [XLEN-1:0] y,
                                    input logic [XLEN-1:0] s);
    return (x[XLEN-1] == y[XLEN-1]) && (s[XLEN-1] != x[XLEN-1]);
  endfunction

endpackage

// File: rtl/alu_trap_decode.sv
module alu_trap_decode
  import alu_trap_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output dec_t            dec,
  output logic            is_unsigned
);

  logic [OPC_W-1:0]  opc;
  logic [FN_W-1:0]   fn;
  logic [SH_W-1:0]   sh;
  logic [RIDX_W-1:0] rt_f;
  logic [RIDX_W-1:0] rd_f;
  logic [IMM_W-1:0]  imm_f;
  logic              unused_rs;

  assign opc       = instr[XLEN-1:OPC_LSB];
  assign rt_f      = instr[RS_LSB-1:RT_LSB];
  assign rd_f      = instr[RT_LSB-1:RD_LSB];
  assign sh        = instr[RD_LSB-1:SH_LSB];
  assign fn        = instr[FN_W-1:0];
  assign imm_f     = instr[IMM_W-1:0];
  assign unused_rs = ^instr[OPC_LSB-1:RS_LSB];

  always_comb begin
    dec         = '0;
    dec.op      = ALU_NOP;
    is_unsigned = 1'b0;
    case (opc)
      OPC_REGOP: begin
        if (sh == '0) begin
          case (fn)
            FN_ADD: begin
              dec.legal   = 1'b1;
              dec.op      = ALU_ADD;
              dec.trap_en = 1'b1;
            end
            FN_ADDU: begin
              dec.legal   = 1'b1;
              dec.op      = ALU_ADD;
              is_unsigned = 1'b1;
            end
            FN_AND: begin
              dec.legal = 1'b1;
              dec.op    = ALU_AND;
            end
            default: ;
          endcase
          if (dec.legal) dec.dest = rd_f;
        end
      end
      OPC_ADDI: begin
        dec.legal   = 1'b1;
        dec.op      = ALU_ADD;
        dec.use_imm = 1'b1;
        dec.trap_en = 1'b1;
        dec.dest    = rt_f;
        dec.imm_val = imm_sext(imm_f);
      end
      OPC_ADDIU: begin
        dec.legal   = 1'b1;
        dec.op      = ALU_ADD;
        dec.use_imm = 1'b1;
        dec.dest    = rt_f;
        dec.imm_val = imm_sext(imm_f);
        is_unsigned = 1'b1;
      end
      OPC_ANDI: begin
        dec.legal   = 1'b1;
        dec.op      = ALU_AND;
        dec.use_imm = 1'b1;
        dec.dest    = rt_f;
        dec.imm_val = imm_zext(imm_f);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_trap_exec.sv
module alu_trap_exec
  import alu_trap_pkg::*;
(
  input  dec_t            dec,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  output logic [XLEN-1:0] res,
  output logic            ovf
);

  logic [XLEN-1:0] b_eff;
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] conj;

  assign b_eff = dec.use_imm ? dec.imm_val : opnd_b;
  assign sum   = wrap_add(opnd_a, b_eff);
  assign conj  = opnd_a & b_eff;

  always_comb begin
    case (dec.op)
      ALU_ADD: res = sum;
      ALU_AND: res = conj;
      default: res = '0;
    endcase
  end

  assign ovf = dec.legal && dec.trap_en && (dec.op == ALU_ADD) &&
               twos_ovf(opnd_a, b_eff, sum);

endmodule

// File: rtl/alu_trap_commit.sv
module alu_trap_commit
  import alu_trap_pkg::*;
(
  input  logic              legal,
  input  logic              ovf,
  input  logic [RIDX_W-1:0] dest,
  output logic              zero_dest,
  output logic              wr_ok
);

  assign zero_dest = (dest == '0);
  assign wr_ok     = legal && !ovf && !zero_dest;

endmodule

// File: rtl/alu_trap_unit.sv
module alu_trap_unit
  import alu_trap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [XLEN-1:0]   instr,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  output logic              out_valid,
  output logic [XLEN-1:0]   result,
  output logic [RIDX_W-1:0] dest_idx,
  output logic              wr_en,
  output logic              ovf_trap,
  output logic              illegal
);

  dec_t            dec;
  logic [XLEN-1:0] ex_res;

  // Named events, also observed by the bound checker.
  logic evt_unsigned;
  logic evt_ovf;
  logic evt_zero_dest;
  logic evt_illegal;
  logic evt_wr;

  alu_trap_decode u_dec (
    .instr       (instr),
    .dec         (dec),
    .is_unsigned (evt_unsigned)
  );

  alu_trap_exec u_exe (
    .dec    (dec),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .res    (ex_res),
    .ovf    (evt_ovf)
  );

  alu_trap_commit u_cmt (
    .legal     (dec.legal),
    .ovf       (evt_ovf),
    .dest      (dec.dest),
    .zero_dest (evt_zero_dest),
    .wr_ok     (evt_wr)
  );

  assign evt_illegal = !dec.legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      dest_idx  <= '0;
      wr_en     <= 1'b0;
      ovf_trap  <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && evt_wr;
      ovf_trap  <= in_valid && evt_ovf;
      illegal   <= in_valid && evt_illegal;
      if (in_valid) begin
        result   <= evt_illegal ? '0 : ex_res;
        dest_idx <= dec.dest;
      end
    end
  end

endmodule

// File: rtl/alu_trap_chk.sv
module alu_trap_chk
  import alu_trap_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              evt_unsigned,
  input logic              out_valid,
  input logic [XLEN-1:0]   result,
  input logic [RIDX_W-1:0] dest_idx,
  input logic              wr_en,
  input logic              ovf_trap,
  input logic              illegal
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!out_valid && !wr_en && !ovf_trap && !illegal)
        else $error("R1 outputs active during reset");
    end
  end

  a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !wr_en && !ovf_trap && !illegal));

  a_r6_trap_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> (!wr_en && out_valid));

  a_r7_unsigned_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && evt_unsigned) |=> !ovf_trap);

  a_r8_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (dest_idx != '0));

  a_r9_illegal_alone: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wr_en && !ovf_trap && result == '0 && dest_idx == '0));

endmodule

bind alu_trap_unit alu_trap_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .evt_unsigned (evt_unsigned),
  .out_valid    (out_valid),
  .result       (result),
  .dest_idx     (dest_idx),
  .wr_en        (wr_en),
  .ovf_trap     (ovf_trap),
  .illegal      (illegal)
);

// File: tb/sim_alu_trap_unit.sv
`timescale 1ns/1ps
module sim_alu_trap_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        out_valid;
  logic [31:0] result;
  logic [4:0]  dest_idx;
  logic        wr_en;
  logic        ovf_trap;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_trap_unit u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .out_valid (out_valid),
    .result    (result),
    .dest_idx  (dest_idx),
    .wr_en     (wr_en),
    .ovf_trap  (ovf_trap),
    .illegal   (illegal)
  );

  // {instr, opnd_a, opnd_b, result, dest, wr_en, ovf_trap, illegal}
  localparam int NV = 17;
  localparam logic [135:0] VEC [NV] = '{
    {32'h00221820, 32'h00000005, 32'h00000007, 32'h0000000C, 5'd3, 1'b1, 1'b0, 1'b0}, // R3 add
    {32'h00221820, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 5'd3, 1'b0, 1'b1, 1'b0}, // R6 pos ovf
    {32'h00221820, 32'h80000000, 32'h80000000, 32'h00000000, 5'd3, 1'b0, 1'b1, 1'b0}, // R6 neg ovf
    {32'h00221820, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFFE, 5'd3, 1'b1, 1'b0, 1'b0}, // R6 mixed
    {32'h00221821, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 5'd3, 1'b1, 1'b0, 1'b0}, // R7 addu
    {32'h00221824, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 5'd3, 1'b1, 1'b0, 1'b0}, // R3 and
    {32'h2025FFFF, 32'h00000010, 32'hDEADBEEF, 32'h0000000F, 5'd5, 1'b1, 1'b0, 1'b0}, // R4 sext
    {32'h20257FFF, 32'h7FFF8001, 32'h00000000, 32'h80000000, 5'd5, 1'b0, 1'b1, 1'b0}, // R6 imm ovf
    {32'h2425FFFF, 32'h00000000, 32'h12345678, 32'hFFFFFFFF, 5'd5, 1'b1, 1'b0, 1'b0}, // R4 addiu
    {32'h24250001, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 5'd5, 1'b1, 1'b0, 1'b0}, // R4 wrap
    {32'h3025FFFF, 32'h12345678, 32'hFFFFFFFF, 32'h00005678, 5'd5, 1'b1, 1'b0, 1'b0}, // R5 zext
    {32'h00220020, 32'h00000001, 32'h00000001, 32'h00000002, 5'd0, 1'b0, 1'b0, 1'b0}, // R8 rd 0
    {32'h20200001, 32'h7FFFFFFF, 32'h00000000, 32'h80000000, 5'd0, 1'b0, 1'b1, 1'b0}, // R8 rt 0 ovf
    {32'h00221860, 32'h00000001, 32'h00000002, 32'h00000000, 5'd0, 1'b0, 1'b0, 1'b1}, // R9 shamt
    {32'h00221822, 32'h00000009, 32'h00000002, 32'h00000000, 5'd0, 1'b0, 1'b0, 1'b1}, // R9 func
    {32'h3425FFFF, 32'h00000009, 32'h00000002, 32'h00000000, 5'd0, 1'b0, 1'b0, 1'b1}, // R9 opcode
    {32'h24250001, 32'h7FFFFFFF, 32'h00000000, 32'h80000000, 5'd5, 1'b1, 1'b0, 1'b0}  // R7 addiu
  };

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [135:0] v);
    if (v[0]) return "R9";
    if (v[1]) return "R6";
    if (v[7:3] == 5'd0) return "R8";
    if (v[135:130] == 6'h09 || (v[135:130] == 6'h00 && v[109:104] == 6'h21)) return "R7";
    if (v[135:130] == 6'h0C) return "R5";
    if (v[135:130] == 6'h00) return "R3";
    return "R4";
  endfunction

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1", "flags", {29'd0, wr_en, ovf_trap, illegal}, 32'd0);
    rst_n = 1'b1;

    // Table walk, back to back.
    for (int i = 0; i < NV; i++) begin
      logic [135:0] v;
      string t;
      v = VEC[i];
      t = tag_of(v);
      in_valid = 1'b1;
      instr  = v[135:104];
      opnd_a = v[103:72];
      opnd_b = v[71:40];
      @(negedge clk);
      chk("R2", "out_valid", {31'd0, out_valid}, 32'd1);
      chk(t, "result", result, v[39:8]);
      chk(t, "dest_idx", {27'd0, dest_idx}, {27'd0, v[7:3]});
      chk(t, "wr_en", {31'd0, wr_en}, {31'd0, v[2]});
      chk(t, "ovf_trap", {31'd0, ovf_trap}, {31'd0, v[1]});
      chk(t, "illegal", {31'd0, illegal}, {31'd0, v[0]});
    end

    // R2: idle cycle with an overflowing add on the bus.
    in_valid = 1'b0;
    instr  = 32'h00221820;
    opnd_a = 32'h7FFFFFFF;
    opnd_b = 32'h00000001;
    @(negedge clk);
    chk("R2", "idle out_valid", {31'd0, out_valid}, 32'd0);
    chk("R2", "idle flags", {29'd0, wr_en, ovf_trap, illegal}, 32'd0);

    // R4: opnd_b has no effect on the add-immediate result.
    in_valid = 1'b1;
    instr  = 32'h24250003;
    opnd_a = 32'h00000100;
    opnd_b = 32'hFFFFFFFF;
    @(negedge clk);
    chk("R4", "b ignored result", result, 32'h00000103);

    // R1: reset asserted with a valid result on the outputs.
    instr  = 32'h00221821;
    opnd_a = 32'h00000001;
    opnd_b = 32'h00000001;
    @(negedge clk);
    chk("R2", "pre-reset wr_en", {31'd0, wr_en}, 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R1", "mid reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1", "mid reset wr_en", {31'd0, wr_en}, 32'd0);
    @(negedge clk);
    chk("R1", "held reset out_valid", {31'd0, out_valid}, 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end

endmodule